// File: doc/BRIEF.md
# Packet Framing Rule Checker

This block sits beside a link that carries a 2-bit control code from one block to another, and it reports any cycle in which the code sequence breaks the framing rules. The payload is not inspected. A packet opens on a beat code. At least one middle beat follows it, and idle cycles may appear between beats. The packet closes on an end code, and that end code must come in the cycle right after a middle beat. The start and middle beats use the same encoding, so the checker tells them apart by remembering whether a packet is open and what the previous cycle carried.

On a violation the checker raises a one-cycle pulse and a type code, and it sets a sticky flag that stays up until software-independent logic pulses a clear input. It then drops the packet it was tracking and treats the next beat code as a fresh start. Packets that end correctly are counted in a saturating counter. The checker is meant to be proven in both directions, so the bench drives legal and illegal sequences on purpose.

Top module: `pktFrameChecker`

## Requirements
- R1: While reset is asserted and at the first edge after it, errSticky, errPulse, errType and goodCount are all 0.
- R2: Codes are 2'b00 idle, 2'b01 beat and 2'b11 end. The sequence beat, beat, end raises no error, and goodCount rises by 1 in the cycle after the end code is sampled.
- R3: Any number of idle cycles between the start beat and a middle beat, or between two middle beats, raises no error.
- R4: An end code that arrives while a packet is open, with an idle cycle directly before it, is a violation of type 1.
- R5: An end code that arrives while no packet is open is a violation of type 2.
- R6: The code 2'b10 is a violation of type 3, whatever the state.
- R7: An end code in the cycle directly after the start beat is a violation of type 4.
- R8: errPulse is high for exactly the one cycle after each cycle that carried a violating code. In that same cycle errType shows the violation's type.
- R9: errSticky sets on any violation and holds until errClear is sampled high. If a violation and a clear come in the same cycle, the flag stays set. A clear with no violation returns errType to 0.
- R10: After a violation no packet is open, so the next 2'b01 is a start beat.
- R11: goodCount saturates at its all-ones value, and it never changes except on a correct end.
- R12: errType holds the type of the most recent violation until a later violation or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| linkCode | input | 2 | Control code observed on the link |
| errClear | input | 1 | Clears the sticky flag and type code |
| errSticky | output | 1 | Set by any violation, held until cleared |
| errPulse | output | 1 | One-cycle violation strobe |
| errType | output | 3 | Type of the latest violation (0 = none) |
| goodCount | output | CNT_W | Saturating count of correctly ended packets |

## Verification
Suppose the checker mistakes a middle beat for a start, or forgets an idle gap. The type code is then wrong, or a spurious pulse appears or an expected one is missing, and this shows one cycle after the next end code. Any state error surfaces by the time the packet closes. If the checker fails to close the packet after a violation, the next beat-then-end pair shows it: that pair must report type 4. A slip in the counter shows up at the next correct end.

// File: rtl/pktChkPkg.sv
package pktChkPkg;

  localparam logic [1:0] CODE_IDLE = 2'b00;
  localparam logic [1:0] CODE_BEAT = 2'b01;
  localparam logic [1:0] CODE_RSVD = 2'b10;
  localparam logic [1:0] CODE_END  = 2'b11;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_NO_MID    = 3'd1,
    ERR_ORPHAN    = 3'd2,
    ERR_RSVD      = 3'd3,
    ERR_EARLY_END = 3'd4
  } errKind_t;

  typedef enum logic [1:0] {
    ST_CLOSED      = 2'd0,
    ST_AFTER_START = 2'd1,
    ST_OPEN_GAP    = 2'd2,
    ST_AFTER_MID   = 2'd3
  } frameState_t;

  typedef struct packed {
    logic     flagErr;
    errKind_t errKind;
    logic     goodEnd;
  } ctrlStrobe_t;

endpackage

// File: rtl/pktFrameFsm.sv
module pktFrameFsm
  import pktChkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  linkCode,
  output ctrlStrobe_t strobe
);

  frameState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.flagErr = 1'b0;
    strobe.errKind = ERR_NONE;
    strobe.goodEnd = 1'b0;
    unique case (linkCode)
      CODE_RSVD: begin
        strobe.flagErr = 1'b1;
        strobe.errKind = ERR_RSVD;
        stateNext      = ST_CLOSED;
      end
      CODE_END: begin
        stateNext = ST_CLOSED;
        unique case (state)
          ST_CLOSED:      begin strobe.flagErr = 1'b1; strobe.errKind = ERR_ORPHAN;    end
          ST_AFTER_START: begin strobe.flagErr = 1'b1; strobe.errKind = ERR_EARLY_END; end
          ST_OPEN_GAP:    begin strobe.flagErr = 1'b1; strobe.errKind = ERR_NO_MID;    end
          ST_AFTER_MID:   strobe.goodEnd = 1'b1;
          default:        ;
        endcase
      end
      CODE_BEAT: stateNext = (state == ST_CLOSED) ? ST_AFTER_START : ST_AFTER_MID;
      default:   stateNext = (state == ST_CLOSED) ? ST_CLOSED : ST_OPEN_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CLOSED;
    else       state <= stateNext;
  end

  // R10
  closes_after_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagErr |=> (state == ST_CLOSED));

  // R7
  early_end_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.errKind == ERR_EARLY_END) |-> ($past(linkCode) == CODE_BEAT));

endmodule

// File: rtl/pktFrameDatapath.sv
module pktFrameDatapath
  import pktChkPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             errClear,
  output logic             errSticky,
  output logic             errPulse,
  output logic [2:0]       errType,
  output logic [CNT_W-1:0] goodCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errSticky <= 1'b0;
      errPulse  <= 1'b0;
      errType   <= 3'd0;
      goodCount <= '0;
    end else begin
      errPulse <= strobe.flagErr;
      if (strobe.flagErr) begin
        errSticky <= 1'b1;
        errType   <= strobe.errKind;
      end else if (errClear) begin
        errSticky <= 1'b0;
        errType   <= 3'd0;
      end
      if (strobe.goodEnd && goodCount != CNT_MAX)
        goodCount <= goodCount + 1'b1;
    end
  end

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && !errClear) |=> errSticky);

  // R11
  no_decrement_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (goodCount >= $past(goodCount)));

  // R8
  pulse_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (errType != 3'd0 && errSticky));

endmodule

// File: rtl/pktFrameChecker.sv
module pktFrameChecker
  import pktChkPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       linkCode,
  input  logic             errClear,
  output logic             errSticky,
  output logic             errPulse,
  output logic [2:0]       errType,
  output logic [CNT_W-1:0] goodCount
);

  ctrlStrobe_t strobe;

  pktFrameFsm uFsm (
    .clk      (clk),
    .rstN     (rstN),
    .linkCode (linkCode),
    .strobe   (strobe)
  );

  pktFrameDatapath #(.CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .errClear  (errClear),
    .errSticky (errSticky),
    .errPulse  (errPulse),
    .errType   (errType),
    .goodCount (goodCount)
  );

  // R6
  rsvd_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && errType == 3'd3) |-> ($past(linkCode) == CODE_RSVD));

  // R4
  no_mid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && errType == 3'd1) |-> ($past(linkCode) == CODE_END && $past(linkCode, 2) == CODE_IDLE));

  // R2
  count_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goodCount != $past(goodCount)) |-> ($past(linkCode) == CODE_END && !errPulse));

endmodule

// File: tb/sim_pktFrameChecker.sv
`timescale 1ns/1ps
module sim_pktFrameChecker;

  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] linkCode = 2'b00;
  logic errClear = 1'b0;
  logic errSticky, errPulse;
  logic [2:0] errType;
  logic [CW-1:0] goodCount;

  int checks = 0;
  int fails = 0;

  int mSt = 0;
  int mCnt = 0;
  int mType = 0;
  bit mSticky = 1'b0;
  bit mPulse = 1'b0;

  always #10 clk = ~clk;

  pktFrameChecker #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .linkCode(linkCode), .errClear(errClear),
    .errSticky(errSticky), .errPulse(errPulse), .errType(errType), .goodCount(goodCount)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected behaviour from the requirements: state 0 closed, 1 after start,
  // 2 open with a gap, 3 after middle.
  task automatic step(input int code, input bit clr, input string req);
    int t;
    bit good;
    t = 0;
    good = 1'b0;
    if (code == 2) begin
      t = 3; mSt = 0;
    end else if (code == 3) begin
      case (mSt)
        0: t = 2;
        1: t = 4;
        2: t = 1;
        default: good = 1'b1;
      endcase
      mSt = 0;
    end else if (code == 1) begin
      mSt = (mSt == 0) ? 1 : 3;
    end else begin
      mSt = (mSt == 0) ? 0 : 2;
    end
    mPulse = (t != 0);
    if (mPulse) begin mSticky = 1'b1; mType = t; end
    else if (clr) begin mSticky = 1'b0; mType = 0; end
    if (good && mCnt < CMAX) mCnt++;
    @(negedge clk);
    linkCode = code[1:0];
    errClear = clr;
    @(posedge clk);
    #1;
    chk(int'(errPulse), int'(mPulse), req);
    chk(int'(errType), mType, req);
    chk(int'(errSticky), int'(mSticky), req);
    chk(int'(goodCount), mCnt, req);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(int'(errSticky), 0, "R1");
    chk(int'(errPulse), 0, "R1");
    chk(int'(errType), 0, "R1");
    chk(int'(goodCount), 0, "R1");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk(int'(goodCount), 0, "R1");

    // R2: plain packet
    step(1, 0, "R2"); step(1, 0, "R2"); step(3, 0, "R2");
    chk(int'(goodCount), 1, "R2");
    // R3: idle gaps
    step(1, 0, "R3"); step(0, 0, "R3"); step(0, 0, "R3"); step(1, 0, "R3");
    step(0, 0, "R3"); step(1, 0, "R3"); step(3, 0, "R3");
    chk(int'(errSticky), 0, "R3");
    // R4: gap before end
    step(1, 0, "R4"); step(1, 0, "R4"); step(0, 0, "R4"); step(3, 0, "R4");
    chk(int'(errType), 1, "R4");
    // R5: orphan end
    step(3, 0, "R5");
    chk(int'(errType), 2, "R5");
    // R8: pulse lasts one cycle
    step(0, 0, "R8");
    chk(int'(errPulse), 0, "R8");
    // R9: clear, then same-cycle violation and clear
    step(0, 1, "R9");
    chk(int'(errSticky), 0, "R9");
    step(2, 1, "R9");
    chk(int'(errSticky), 1, "R9");
    // R6: reserved inside an open packet
    step(0, 1, "R6"); step(1, 0, "R6"); step(2, 0, "R6");
    chk(int'(errType), 3, "R6");
    // R10: beat after violation is a start, so beat then end is type 4
    step(1, 0, "R10"); step(3, 0, "R10");
    chk(int'(errType), 4, "R10");
    // R7: start then end; R12 type kept over idles
    step(0, 1, "R7"); step(1, 0, "R7"); step(3, 0, "R7");
    chk(int'(errType), 4, "R7");
    step(0, 0, "R12"); step(0, 0, "R12");
    chk(int'(errType), 4, "R12");

    // R11: saturation
    for (int i = 0; i < CMAX + 4; i++) begin
      step(1, 0, "R11"); step(1, 0, "R11"); step(3, 0, "R11");
    end
    chk(int'(goodCount), CMAX, "R11");

    // R8 sweep: every 4-code sequence from the closed state
    for (int s = 0; s < 256; s++) begin
      step(2, 0, "R8");
      step(0, 1, "R9");
      for (int k = 0; k < 4; k++) step((s >> (2 * k)) & 3, 0, "R8");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule